// File: doc/BRIEF.md
# Memory-Mapped Receive and Transmit Device Pair

This block sits on a simple memory-mapped register bus and presents two small devices to a CPU. The receive side captures a byte each time its strobe pulses, holds it in a data register and raises a ready flag. The transmit side takes a 16-bit word from the CPU and plays it out on a transmit interface for a fixed, parameterised number of clock cycles.

The status bits have split ownership. The device sets the receive-ready flag, and the CPU clears it with a read-modify-write of the status register. The CPU sets the transmit-enable bit to start a send, and the device clears it and raises its ready-to-send flag again when the send finishes. Each device drives a level interrupt request, gated by its own enable bit.

Top module: `mmio_dev_pair`

## Requirements
- R1: After reset, the receive status (0xA0) reads 0x00, the transmit status (0xB0) reads 0x01 (ready-to-send set), both data registers read 0, and irqIn, irqOut and txActive are low.
- R2: A pulse on rxStrobe stores rxByte in the receive data register (0xA1, read zero-extended to 16 bits) and sets receive status bit 0. The CPU cannot write 0xA1.
- R3: A write to 0xA0 with bit 0 = 0 clears the ready flag. A write with bit 0 = 1 never sets it. When rxStrobe arrives in the same cycle as a clearing write, the flag ends up set.
- R4: A strobe that arrives while the ready flag is set overwrites the data register and sets the overrun flag (0xA0 bit 1). The overrun flag stays set until a write to 0xA0 with bit 1 = 0.
- R5: Bit 7 of each status register is that device's interrupt enable. irqIn is high exactly while receive-ready and its enable are both 1. irqOut is high exactly while ready-to-send and its enable are both 1.
- R6: A write to 0xB0 with bit 1 = 1 while no send is running starts a send. Transmit enable (0xB0 bit 1) and txActive go high, ready-to-send (bit 0) goes low, and txWord takes the value of 0xB1. After exactly TX_CYCLES cycles, transmit enable and txActive drop and ready-to-send returns to 1.
- R7: While a send is running, writes to 0xB0 neither restart nor abort it, and writes to 0xB1 leave txWord unchanged.
- R8: 0xB1 holds a full 16-bit word that the CPU can write and read back.
- R9: Reads of any address other than 0xA0, 0xA1, 0xB0 and 0xB1 return 0, and writes to them change nothing.
- R10: busRdata shows the addressed register in the cycle after busRd is high, and 0 in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, one cycle after busRd |
| rxStrobe | input | 1 | Receive byte strobe |
| rxByte | input | 8 | Received byte |
| txActive | output | 1 | High while a send is running |
| txWord | output | 16 | Word being sent |
| irqIn | output | 1 | Receive interrupt request (level) |
| irqOut | output | 1 | Transmit interrupt request (level) |

## Verification
Register writes and receive strobes take effect at the next clock edge, so status bits, interrupt levels, txActive and txWord are checked at the falling edge after that edge. Read data is registered: a scoreboard queues each expected value when the read is issued, and the monitor compares it at the falling edge after the edge that captured it. The send length is measured by counting the falling edges at which txActive is high, from the edge that starts the send until it drops, including cycles taken up by interfering bus writes. That count must equal TX_CYCLES exactly.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  typedef enum logic [2:0] {
    RD_NONE    = 3'd0,
    RD_IN_STS  = 3'd1,
    RD_IN_DAT  = 3'd2,
    RD_OUT_STS = 3'd3,
    RD_OUT_DAT = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic   inStsWr;
    logic   outStsWr;
    logic   outDatWr;
    logic   txStart;
    logic   txFinish;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/mmio_ctrl.sv
module mmio_ctrl
  import mmio_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TX_CYCLES   = 12,
  parameter logic [ADDR_W-1:0] IN_STS_ADDR  = 8'hA0,
  parameter logic [ADDR_W-1:0] IN_DAT_ADDR  = 8'hA1,
  parameter logic [ADDR_W-1:0] OUT_STS_ADDR = 8'hB0,
  parameter logic [ADDR_W-1:0] OUT_DAT_ADDR = 8'hB1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              startBit,
  input  logic              txEnQ,
  output ctlStrobe_t        strb
);

  localparam int CNT_W = $clog2(TX_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TX_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic hitInSts, hitInDat, hitOutSts, hitOutDat;
  logic [CNT_W-1:0] remainQ;

  assign hitInSts  = (busAddr == IN_STS_ADDR);
  assign hitInDat  = (busAddr == IN_DAT_ADDR);
  assign hitOutSts = (busAddr == OUT_STS_ADDR);
  assign hitOutDat = (busAddr == OUT_DAT_ADDR);

  always_comb begin
    strb          = '0;
    strb.inStsWr  = busWr && hitInSts;
    strb.outStsWr = busWr && hitOutSts;
    strb.outDatWr = busWr && hitOutDat;
    strb.txStart  = busWr && hitOutSts && startBit && !txEnQ;
    strb.txFinish = txEnQ && (remainQ == CNT_LAST);
    strb.rdSel    = RD_NONE;
    if (busRd) begin
      if (hitInSts)       strb.rdSel = RD_IN_STS;
      else if (hitInDat)  strb.rdSel = RD_IN_DAT;
      else if (hitOutSts) strb.rdSel = RD_OUT_STS;
      else if (hitOutDat) strb.rdSel = RD_OUT_DAT;
    end
  end

  // Send-length timer: loaded at start, counts down while a send runs
  always_ff @(posedge clk) begin
    if (!rstN)              remainQ <= '0;
    else if (strb.txStart)  remainQ <= CNT_LOAD;
    else if (txEnQ && remainQ != '0) remainQ <= remainQ - CNT_W'(1);
  end

  // R7
  restart_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEnQ |-> !strb.txStart);

  // R6
  finish_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txFinish |=> !strb.txFinish);

endmodule

// File: rtl/mmio_dpath.sv
module mmio_dpath
  import mmio_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [OUT_W-1:0] busWdata,
  input  logic             rxStrobe,
  input  logic [IN_W-1:0]  rxByte,
  output logic [OUT_W-1:0] busRdata,
  output logic             txEnQ,
  output logic             txActive,
  output logic [OUT_W-1:0] txWord,
  output logic             irqIn,
  output logic             irqOut
);

  localparam int STS_W = 8;
  localparam int IE_BIT = STS_W - 1;

  logic             inReadyQ, inOvrQ, inIeQ;
  logic [IN_W-1:0]  inDataQ;
  logic             rtsQ, outIeQ;
  logic [OUT_W-1:0] outDataQ, txWordQ, rdataQ;
  logic             ovrAfterWr;
  logic [STS_W-1:0] inSts, outSts;

  assign ovrAfterWr = strb.inStsWr ? (inOvrQ && busWdata[1]) : inOvrQ;

  // Receive side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReadyQ <= 1'b0;
      inOvrQ   <= 1'b0;
      inIeQ    <= 1'b0;
      inDataQ  <= '0;
    end else begin
      if (strb.inStsWr) inIeQ <= busWdata[IE_BIT];
      if (rxStrobe) begin
        inDataQ  <= rxByte;
        inReadyQ <= 1'b1;
        inOvrQ   <= ovrAfterWr || inReadyQ;
      end else begin
        inOvrQ <= ovrAfterWr;
        if (strb.inStsWr && !busWdata[0]) inReadyQ <= 1'b0;
      end
    end
  end

  // Transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtsQ     <= 1'b1;
      txEnQ    <= 1'b0;
      outIeQ   <= 1'b0;
      outDataQ <= '0;
      txWordQ  <= '0;
    end else begin
      if (strb.outStsWr) outIeQ   <= busWdata[IE_BIT];
      if (strb.outDatWr) outDataQ <= busWdata;
      if (strb.txStart) begin
        txEnQ   <= 1'b1;
        rtsQ    <= 1'b0;
        txWordQ <= outDataQ;
      end else if (strb.txFinish) begin
        txEnQ <= 1'b0;
        rtsQ  <= 1'b1;
      end
    end
  end

  always_comb begin
    inSts         = '0;
    inSts[0]      = inReadyQ;
    inSts[1]      = inOvrQ;
    inSts[IE_BIT] = inIeQ;
    outSts         = '0;
    outSts[0]      = rtsQ;
    outSts[1]      = txEnQ;
    outSts[IE_BIT] = outIeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdataQ <= '0;
    else begin
      unique case (strb.rdSel)
        RD_IN_STS:  rdataQ <= OUT_W'(inSts);
        RD_IN_DAT:  rdataQ <= OUT_W'(inDataQ);
        RD_OUT_STS: rdataQ <= OUT_W'(outSts);
        RD_OUT_DAT: rdataQ <= outDataQ;
        default:    rdataQ <= '0;
      endcase
    end
  end

  assign busRdata = rdataQ;
  assign txActive = txEnQ;
  assign txWord   = txWordQ;
  assign irqIn    = inReadyQ && inIeQ;
  assign irqOut   = rtsQ && outIeQ;

  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> inReadyQ);

  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxStrobe && inReadyQ) |=> inOvrQ);

  // R6
  tx_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnQ) |-> rtsQ);

  // R7
  tx_word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEnQ && $past(txEnQ)) |-> $stable(txWordQ));

  // R6
  rts_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txEnQ && rtsQ));

endmodule

// File: rtl/mmio_dev_pair.sv
module mmio_dev_pair
  import mmio_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int IN_W      = 8,
  parameter int OUT_W     = 16,
  parameter int TX_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [OUT_W-1:0]  busWdata,
  output logic [OUT_W-1:0]  busRdata,
  input  logic              rxStrobe,
  input  logic [IN_W-1:0]   rxByte,
  output logic              txActive,
  output logic [OUT_W-1:0]  txWord,
  output logic              irqIn,
  output logic              irqOut
);

  ctlStrobe_t strb;
  logic       txEnQ;

  mmio_ctrl #(.ADDR_W(ADDR_W), .TX_CYCLES(TX_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .startBit(busWdata[1]), .txEnQ(txEnQ), .strb(strb)
  );

  mmio_dpath #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .rxStrobe(rxStrobe), .rxByte(rxByte), .busRdata(busRdata),
    .txEnQ(txEnQ), .txActive(txActive), .txWord(txWord),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  // R5
  irq_out_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> !txActive);

endmodule

// File: tb/mmio_dev_pair_tb.sv
module mmio_dev_pair_tb;

  localparam int TXC = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        rxStrobe = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        txActive;
  logic [15:0] txWord;
  logic        irqIn, irqOut;

  int nChecks = 0;
  int nFails  = 0;
  logic rdSeen = 1'b0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  mmio_dev_pair #(.TX_CYCLES(TXC)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxStrobe(rxStrobe),
    .rxByte(rxByte), .txActive(txActive), .txWord(txWord),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  // Driver: issue read and push expected value for the monitor
  task automatic busRead(input logic [7:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic rxPulse(input logic [7:0] b);
    @(negedge clk);
    rxByte = b; rxStrobe = 1'b1;
    @(negedge clk);
    rxStrobe = 1'b0;
  endtask

  // Monitor: compare read data one cycle after the read edge
  always @(posedge clk) rdSeen <= busRd;
  always @(negedge clk) begin
    if (rstN && rdSeen) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R10: unexpected read data 0x%0h expected none", busRdata);
      end else begin
        chk(tagQ.pop_front(), busRdata, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irqIn", {15'd0, irqIn}, 16'd0);
    chk("R1 irqOut", {15'd0, irqOut}, 16'd0);
    chk("R1 txActive", {15'd0, txActive}, 16'd0);
    chk("R10 idle rdata", busRdata, 16'd0);
    busRead(8'hA0, 16'h0000, "R1 in status");
    busRead(8'hB0, 16'h0001, "R1 out status");
    busRead(8'hA1, 16'h0000, "R1 in data");
    busRead(8'hB1, 16'h0000, "R1 out data");
    @(negedge clk);
    chk("R10 rdata zero after no read", busRdata, 16'd0);

    // R2 capture
    rxPulse(8'h5A);
    chk("R5 irqIn disabled", {15'd0, irqIn}, 16'd0);
    busRead(8'hA1, 16'h005A, "R2 in data");
    busRead(8'hA0, 16'h0001, "R2 ready set");
    busWrite(8'hA1, 16'hFFFF);
    busRead(8'hA1, 16'h005A, "R2 data not writable");

    // R5 enable, write-1 to ready keeps it
    busWrite(8'hA0, 16'h0081);
    chk("R5 irqIn enabled", {15'd0, irqIn}, 16'd1);
    busRead(8'hA0, 16'h0081, "R3 write one keeps ready");

    // R4 overrun
    rxPulse(8'hC3);
    busRead(8'hA1, 16'h00C3, "R4 overwrite");
    busRead(8'hA0, 16'h0083, "R4 overrun set");
    busWrite(8'hA0, 16'h0082);
    busRead(8'hA0, 16'h0082, "R4 overrun sticky, R3 ready cleared");
    chk("R5 irqIn low after clear", {15'd0, irqIn}, 16'd0);
    busWrite(8'hA0, 16'h0080);
    busRead(8'hA0, 16'h0080, "R4 overrun cleared");

    // R3 write-1 does not set ready
    busWrite(8'hA0, 16'h0001);
    busRead(8'hA0, 16'h0000, "R3 write one no set");

    // R3 strobe wins over same-cycle clear
    @(negedge clk);
    busAddr = 8'hA0; busWdata = 16'h0000; busWr = 1'b1;
    rxByte = 8'h11; rxStrobe = 1'b1;
    @(negedge clk);
    busWr = 1'b0; rxStrobe = 1'b0;
    busRead(8'hA0, 16'h0001, "R3 strobe wins");
    busRead(8'hA1, 16'h0011, "R3 strobe data");

    // R8, R6 first send with interrupt enabled
    busWrite(8'hB1, 16'hBEEF);
    busRead(8'hB1, 16'hBEEF, "R8 out data readback");
    busWrite(8'hB0, 16'h0082);
    chk("R6 txActive high", {15'd0, txActive}, 16'd1);
    chk("R6 txWord", txWord, 16'hBEEF);
    chk("R5 irqOut low while sending", {15'd0, irqOut}, 16'd0);
    cnt = 1;
    while (txActive) begin
      @(negedge clk);
      if (txActive) cnt++;
    end
    chk("R6 send length", 16'(cnt), 16'(TXC));
    chk("R5 irqOut after send", {15'd0, irqOut}, 16'd1);
    busRead(8'hB0, 16'h0081, "R6 status after send");

    // R7 interference during second send, interrupt disabled
    busWrite(8'hB1, 16'h1234);
    busWrite(8'hB0, 16'h0002);
    busWrite(8'hB1, 16'h5678);
    busWrite(8'hB0, 16'h0000);
    busWrite(8'hB0, 16'h0002);
    chk("R7 no abort", {15'd0, txActive}, 16'd1);
    chk("R7 txWord held", txWord, 16'h1234);
    cnt = 7;
    while (txActive) begin
      @(negedge clk);
      if (txActive) cnt++;
    end
    chk("R7 length unchanged by writes", 16'(cnt), 16'(TXC));
    chk("R5 irqOut disabled", {15'd0, irqOut}, 16'd0);
    busRead(8'hB1, 16'h5678, "R8 data updated during send");
    busRead(8'hB0, 16'h0001, "R6 idle status");

    // R9 unmapped
    busWrite(8'hA2, 16'hFFFF);
    busWrite(8'hB2, 16'hFFFF);
    busWrite(8'h00, 16'hFFFF);
    busRead(8'hA2, 16'h0000, "R9 unmapped read A2");
    busRead(8'h00, 16'h0000, "R9 unmapped read 00");
    busRead(8'hA0, 16'h0001, "R9 in status untouched");
    busRead(8'hB1, 16'h5678, "R9 out data untouched");
    chk("R9 no send started", {15'd0, txActive}, 16'd0);

    @(negedge clk);
    @(negedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL R10: actual %0d pending reads expected 0", expQ.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule